// File: doc/BRIEF.md
# I2C bus condition request controller

This block is the command and mode register of an I2C interface. Software writes a byte to ask for a start, a repeated start or a stop condition, and to pick master or slave role and transmit or receive direction. The block keeps those requests until the bus side reports that they are done. It also tracks whether the bus is occupied, using the start-seen and stop-seen pulses from the line detectors.

A start request does not reach the bus at once. It waits until the bus is free, and then the block raises a one-cycle strobe toward the separate condition generator. Every pending request is dropped when arbitration is lost, when the matching condition is seen on the bus, or when the interface is reset.

The two mode bits are guarded. They accept new values only while a write-permit input is high.

Top module: `i2c_bus_req_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `rd_data` reads 0x00 and `gen_start` is low. Bits 0 and 4 of `rd_data` always read 0, whatever value is written to them.
- R2: The start request sits in bit 1. A write with bit 1 = 1 sets it, and a write with bit 1 = 0 clears it.
- R3: The restart request (bit 2) and the stop request (bit 3) are set by writing 1. Writing 0 to either of them leaves it unchanged.
- R4: The transmit bit (bit 5, 1 = transmit) and the master bit (bit 6, 1 = master) take the written value only when `mode_wr_permit` is 1. Otherwise they keep their value.
- R5: The bus busy flag (bit 7) sets one cycle after a `start_det` pulse and clears one cycle after a `stop_det` pulse. When both pulses arrive in the same cycle, the stop wins. Software writes to bit 7 have no effect.
- R6: `gen_start` is high only while a start request is pending and the busy flag is 0. It is high for exactly one cycle for each pending request.
- R7: A `start_det` pulse clears the start request and the restart request. A `stop_det` pulse clears the stop request.
- R8: A rising edge of the level input `arb_lost` clears all three requests. Holding `arb_lost` high does not block later writes that set requests.
- R9: A cycle with `if_rst` high clears every register bit, including the mode bits and the busy flag.
- R10: When a register write and a hardware clear of the same request bit happen in the same cycle, the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_rst | input | 1 | Interface reset; clears all register bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| mode_wr_permit | input | 1 | Enables writes to the mode bits |
| start_det | input | 1 | Start condition seen on the bus (pulse) |
| stop_det | input | 1 | Stop condition seen on the bus (pulse) |
| arb_lost | input | 1 | Arbitration-lost flag (level) |
| rd_data | output | 8 | Register read value |
| gen_start | output | 1 | Strobe asking the generator to issue a start |

## Verification
The bench builds the block with its default package constants. The register is only eight bits wide, so every write value can be swept with the write permit both low and high. Each run starts from an interface reset, which puts the whole write-side decode, the reserved-bit masking and the first start strobe within reach of arithmetic expectations. Directed sequences then cover busy-gated starts, clears by detection and arbitration loss, and writes that collide with hardware clears.

// File: rtl/i2c_req_pkg.sv
package i2c_req_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REQ  = 3;

    // Field positions; software and the bench decode these.
    localparam int POS_ST   = 1;
    localparam int POS_RS   = 2;
    localparam int POS_SP   = 3;
    localparam int POS_TRS  = 5;
    localparam int POS_MST  = 6;
    localparam int POS_BUSY = 7;

    typedef enum int {
        REQ_START   = 0,
        REQ_RESTART = 1,
        REQ_STOP    = 2
    } req_kind_e;

    typedef struct packed {
        logic               busy;
        logic               mst;
        logic               trs;
        logic [NUM_REQ-1:0] req;
    } ctrl_state_t;

    function automatic int req_pos(input int k);
        return POS_ST + k;
    endfunction

    // Only the start request may be withdrawn by writing 0.
    function automatic bit req_clr_on_zero(input int k);
        return (k == REQ_START);
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input ctrl_state_t s);
        logic [REG_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            v[req_pos(k)] = s.req[k];
        end
        v[POS_TRS]  = s.trs;
        v[POS_MST]  = s.mst;
        v[POS_BUSY] = s.busy;
        return v;
    endfunction

endpackage

// File: rtl/i2c_req_cell.sv
module i2c_req_cell #(
    parameter bit CLR_ON_ZERO = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic hw_clr,
    output logic req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (hw_clr) begin
            req_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_bit) begin
                req_q <= 1'b1;
            end else if (CLR_ON_ZERO) begin
                req_q <= 1'b0;
            end
        end
    end

    // R10: a hardware clear beats any write in the same cycle
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        hw_clr |=> !req_q);

    // R3: a zero write keeps a held request when zero-clear is off
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (!CLR_ON_ZERO && req_q && wr_en && !wr_bit && !hw_clr) |=> req_q);

endmodule

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
    input  logic clk,
    input  logic rst,
    input  logic if_rst,
    input  logic start_det,
    input  logic stop_det,
    output logic busy_q
);

    always_ff @(posedge clk) begin
        if (rst || if_rst) begin
            busy_q <= 1'b0;
        end else if (stop_det) begin
            busy_q <= 1'b0;
        end else if (start_det) begin
            busy_q <= 1'b1;
        end
    end

    // R5: stop detection always leaves the bus free
    a_r5_stop_frees: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !busy_q);

    // R5: a lone start detection marks the bus busy
    a_r5_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det && !if_rst) |=> busy_q);

endmodule

// File: rtl/i2c_mode_bits.sv
module i2c_mode_bits (
    input  logic clk,
    input  logic rst,
    input  logic if_rst,
    input  logic wr_en,
    input  logic permit,
    input  logic wr_trs,
    input  logic wr_mst,
    output logic trs_q,
    output logic mst_q
);

    logic take;
    assign take = wr_en & permit;

    always_ff @(posedge clk) begin
        if (rst || if_rst) begin
            trs_q <= 1'b0;
            mst_q <= 1'b0;
        end else if (take) begin
            trs_q <= wr_trs;
            mst_q <= wr_mst;
        end
    end

    // R4: without permit the mode bits do not move
    a_r4_guarded: assert property (@(posedge clk) disable iff (rst)
        (!permit && !if_rst) |=> ($stable(trs_q) && $stable(mst_q)));

endmodule

// File: rtl/i2c_start_launch.sv
module i2c_start_launch (
    input  logic clk,
    input  logic rst,
    input  logic st_req,
    input  logic busy,
    output logic gen_start
);

    logic launched_q;

    assign gen_start = st_req & ~busy & ~launched_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            launched_q <= 1'b0;
        end else if (!st_req) begin
            launched_q <= 1'b0;
        end else if (gen_start) begin
            launched_q <= 1'b1;
        end
    end

    // R6: one strobe per request
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        gen_start |=> !gen_start);

endmodule

// File: rtl/i2c_bus_req_ctrl.sv
module i2c_bus_req_ctrl
    import i2c_req_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             if_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mode_wr_permit,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             arb_lost,
    output logic [REG_W-1:0] rd_data,
    output logic             gen_start
);

    ctrl_state_t       st;
    logic              arb_q;
    logic              arb_rise;
    logic [NUM_REQ-1:0] hw_clr;

    // Reserved and read-only positions are not decoded on writes.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[0], wr_data[4], wr_data[POS_BUSY]};

    always_ff @(posedge clk) begin
        if (rst) begin
            arb_q <= 1'b0;
        end else begin
            arb_q <= arb_lost;
        end
    end

    assign arb_rise = arb_lost & ~arb_q;

    for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
        if (k == REQ_STOP) begin : g_clr_stop
            assign hw_clr[k] = if_rst | arb_rise | stop_det;
        end else begin : g_clr_start
            assign hw_clr[k] = if_rst | arb_rise | start_det;
        end

        i2c_req_cell #(
            .CLR_ON_ZERO (req_clr_on_zero(k))
        ) i_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_bit (wr_data[req_pos(k)]),
            .hw_clr (hw_clr[k]),
            .req_q  (st.req[k])
        );
    end

    i2c_busy_track i_busy (
        .clk       (clk),
        .rst       (rst),
        .if_rst    (if_rst),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy_q    (st.busy)
    );

    i2c_mode_bits i_mode (
        .clk    (clk),
        .rst    (rst),
        .if_rst (if_rst),
        .wr_en  (wr_en),
        .permit (mode_wr_permit),
        .wr_trs (wr_data[POS_TRS]),
        .wr_mst (wr_data[POS_MST]),
        .trs_q  (st.trs),
        .mst_q  (st.mst)
    );

    i2c_start_launch i_launch (
        .clk       (clk),
        .rst       (rst),
        .st_req    (st.req[REQ_START]),
        .busy      (st.busy),
        .gen_start (gen_start)
    );

    assign rd_data = pack_view(st);

    // R1: reserved positions never read as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data[0] == 1'b0) && (rd_data[4] == 1'b0));

    // R6: strobe only with a pending request on a free bus
    a_r6_free_bus: assert property (@(posedge clk) disable iff (rst)
        gen_start |-> (rd_data[POS_ST] && !rd_data[POS_BUSY]));

    // R8: rising arbitration loss drops every request
    a_r8_arb_clears: assert property (@(posedge clk) disable iff (rst)
        arb_rise |=> (rd_data[POS_SP:POS_ST] == '0));

    // R9: interface reset empties the register
    a_r9_if_reset: assert property (@(posedge clk) disable iff (rst)
        if_rst |=> (rd_data == '0));

    // R7: start detection drops start and restart requests
    a_r7_start_det: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!rd_data[POS_ST] && !rd_data[POS_RS]));

endmodule

// File: tb/test_i2c_bus_req_ctrl.sv
module test_i2c_bus_req_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       if_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mode_wr_permit = 1'b0;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       arb_lost = 1'b0;
    logic [7:0] rd_data;
    logic       gen_start;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    i2c_bus_req_ctrl i_i2c_bus_req_ctrl (
        .clk            (clk),
        .rst            (rst),
        .if_rst         (if_rst),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .mode_wr_permit (mode_wr_permit),
        .start_det      (start_det),
        .stop_det       (stop_det),
        .arb_lost       (arb_lost),
        .rd_data        (rd_data),
        .gen_start      (gen_start)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Called at a negedge: drive, let one posedge pass, return at next negedge.
    task automatic step(input logic we, input logic [7:0] d, input logic perm,
                        input logic sd, input logic pd, input logic al, input logic ir);
        wr_en = we; wr_data = d; mode_wr_permit = perm;
        start_det = sd; stop_det = pd; arb_lost = al; if_rst = ir;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; start_det = 1'b0; stop_det = 1'b0; if_rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input logic perm);
        step(1'b1, d, perm, 1'b0, 1'b0, arb_lost, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, mode_wr_permit, 1'b0, 1'b0, arb_lost, 1'b0);
    endtask

    task automatic clr();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check8("R1 reset", rd_data, 8'h00);
        check1("R1 reset strobe", gen_start, 1'b0);

        // Sweep: R1 R2 R3 R4 R5 R6 under both permit settings
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] d;
                logic [7:0] e;
                d = 8'(v);
                e = {1'b0, (p == 1) ? d[6] : 1'b0, (p == 1) ? d[5] : 1'b0,
                     1'b0, d[3], d[2], d[1], 1'b0};
                clr();
                wr(d, p[0]);
                check8("R1 R2 R3 R4 R5 sweep", rd_data, e);
                check1("R6 sweep strobe", gen_start, d[1]);
            end
        end

        // R2 write zero withdraws start
        clr();
        wr(8'h02, 1'b0);
        wr(8'h00, 1'b0);
        check8("R2 clear by zero", rd_data, 8'h00);

        // R3 write zero keeps restart and stop
        clr();
        wr(8'h0C, 1'b0);
        wr(8'h00, 1'b0);
        check8("R3 zero keeps", rd_data, 8'h0C);

        // R5 R6 busy gating
        clr();
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R5 busy set", rd_data, 8'h80);
        wr(8'hFF, 1'b0);
        check8("R5 busy read-only", rd_data, 8'h8E);
        check1("R6 held while busy", gen_start, 1'b0);
        idle();
        check1("R6 still held", gen_start, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check8("R5 R7 stop frees and drops stop", rd_data, 8'h06);
        check1("R6 strobe on free bus", gen_start, 1'b1);
        idle();
        check1("R6 single pulse", gen_start, 1'b0);
        check8("R6 request stays pending", rd_data, 8'h06);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R7 start det clears start and restart", rd_data, 8'h80);

        // R5 simultaneous start and stop detection: stop wins
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check8("R5 stop wins", rd_data, 8'h00);

        // R8 arbitration loss
        clr();
        wr(8'h0E, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check8("R8 rise clears", rd_data, 8'h00);
        wr(8'h0E, 1'b0);
        check8("R8 held level no clear", rd_data, 8'h0E);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check8("R8 second rise clears", rd_data, 8'h00);
        arb_lost = 1'b0;
        idle();

        // R10 write versus hardware clear
        clr();
        step(1'b1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R10 start det beats write", rd_data, 8'h80);
        step(1'b1, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check8("R10 stop det beats write", rd_data, 8'h00);
        step(1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check8("R10 arb loss beats write", rd_data, 8'h00);
        arb_lost = 1'b0;
        idle();

        // R4 guarded mode bits
        clr();
        wr(8'h60, 1'b1);
        check8("R4 permitted write", rd_data, 8'h60);
        wr(8'h00, 1'b0);
        check8("R4 blocked write", rd_data, 8'h60);
        wr(8'h20, 1'b1);
        check8("R4 second permitted write", rd_data, 8'h20);

        // R9 interface reset clears everything
        clr();
        wr(8'h6E, 1'b1);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R7 R9 preload", rd_data, 8'hE8);
        clr();
        check8("R9 interface reset", rd_data, 8'h00);
        check1("R9 strobe low", gen_start, 1'b0);

        done = 1'b1;
        summary();
    end

endmodule